// File: doc/BRIEF.md
# Non-power-of-two interleave address normalizer

This block takes a system physical address, already stripped of its region base and any hole, and produces the address as seen by one channel of a 3-, 5-, 6-, 10-, 12- or 24-way interleave with a 1 KiB or 2 KiB stripe. The low bits within a stripe are carried through. The bits that select the channel are dropped. The upper bits, with some mode-dependent low bits folded in, are divided by 3 or 5. The remainder of that division is discarded, so the mapping cannot be reversed directly.

A request is a one-cycle `start_i` with the address, a 4-bit mode code and the channel count. The division runs serially, one quotient bit per cycle. `done_o` pulses when the result is ready. `norm_o` and `err_o` keep their values until the next `done_o`. A start that arrives while a division is in progress is dropped. A mode code outside the supported set completes one cycle after it is sampled, with a zero result and the error flag set.

Top module: `np2_addr_normalizer`

## Requirements
- R1: On every successful completion, norm_o[7:0] equals addr_i[7:0] of the accepted request.
- R2: mode_i[0] selects the stripe: 0 = 1 KiB, 1 = 2 KiB. With a 1 KiB stripe, addr_i[11:10] appears at norm_o[9:8]. With a 2 KiB stripe, addr_i[11:9] appears at norm_o[10:8].
- R3: The divisor is 3 when chan_cnt_i is a multiple of 3 and 5 otherwise. The remainder is discarded.
- R4: Layout code mode_i[3:1] = 0 (24 ways): the dividend is addr[63:13] with a 1 KiB stripe and addr[63:14] with a 2 KiB stripe.
- R5: Layout code 1 (12 ways): the dividend is addr[63:12] with a 1 KiB stripe and addr[63:13] with a 2 KiB stripe.
- R6: Layout code 2 (6 or 10 ways): the dividend is {addr[63:12], addr[9]} with a 1 KiB stripe and addr[63:12] with a 2 KiB stripe.
- R7: Layout code 3 (3 or 5 ways): the dividend is {addr[63:12], addr[9:8]} with a 1 KiB stripe and {addr[63:12], addr[8]} with a 2 KiB stripe. In every layout the quotient is placed at bit 10 for a 1 KiB stripe and at bit 11 for a 2 KiB stripe, and truncated to 64 bits.
- R8: Layout codes 4 to 7 are unsupported. done_o rises at the edge that samples start_i, with norm_o = 0 and err_o = 1. A successful completion drives err_o to 0.
- R9: norm_o and err_o change only in a cycle where done_o is high. A start_i raised while a division is in progress is ignored. A start_i raised in the done cycle is accepted.
- R10: For a supported mode, done_o rises for one cycle at the 65th rising edge after the edge that accepts start_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, one cycle |
| addr_i | input | 64 | System physical address, base and hole removed |
| mode_i | input | 4 | [0] stripe size, [3:1] layout code |
| chan_cnt_i | input | 5 | Interleaved channel count |
| norm_o | output | 64 | Normalized channel address |
| done_o | output | 1 | Result-ready pulse |
| err_o | output | 1 | Unsupported mode on the last completion |

## Verification
Two events can share a cycle: the completion of one request and the arrival of the next start. The bench raises start_i in the very cycle that done_o is high. It then checks three things: the new request is accepted, norm_o still shows the previous result through the following busy cycle, and the new result arrives exactly 65 edges later. A second start placed in the middle of a division is judged the same way. The finished result must belong to the first request and keep the same latency.

// File: rtl/np2n_pkg.sv
package np2n_pkg;
  typedef enum logic [2:0] {
    LAYOUT_24   = 3'd0,
    LAYOUT_12   = 3'd1,
    LAYOUT_6_10 = 3'd2,
    LAYOUT_3_5  = 3'd3
  } layout_e;

  localparam int unsigned PASS_W   = 8;
  localparam int unsigned DIVSR_W  = 3;
  localparam logic [DIVSR_W-1:0] DIVSR_THREE = 3'd3;
  localparam logic [DIVSR_W-1:0] DIVSR_FIVE  = 3'd5;
  localparam int unsigned Q_POS_1K = 10;
  localparam int unsigned Q_POS_2K = 11;
endpackage

// File: rtl/nrm_field_map.sv
module nrm_field_map
  import np2n_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned MODE_W = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic [ADDR_W-1:0] dividend_o,
  output logic [ADDR_W-1:0] low_o,
  output logic              wide_o,
  output logic              valid_o
);
  logic [2:0] layout;
  assign layout = mode_i[3:1];
  assign wide_o = mode_i[0];

  always_comb begin
    dividend_o = '0;
    valid_o    = 1'b1;
    unique case (layout)
      LAYOUT_24:
        dividend_o = wide_o ? ADDR_W'(addr_i[ADDR_W-1:14]) : ADDR_W'(addr_i[ADDR_W-1:13]);
      LAYOUT_12:
        dividend_o = wide_o ? ADDR_W'(addr_i[ADDR_W-1:13]) : ADDR_W'(addr_i[ADDR_W-1:12]);
      LAYOUT_6_10:
        dividend_o = wide_o ? ADDR_W'(addr_i[ADDR_W-1:12])
                            : ADDR_W'({addr_i[ADDR_W-1:12], addr_i[9]});
      LAYOUT_3_5:
        dividend_o = wide_o ? ADDR_W'({addr_i[ADDR_W-1:12], addr_i[8]})
                            : ADDR_W'({addr_i[ADDR_W-1:12], addr_i[9:8]});
      default: valid_o = 1'b0;
    endcase
  end

  always_comb begin
    low_o = '0;
    low_o[PASS_W-1:0] = addr_i[PASS_W-1:0];
    if (wide_o) low_o[10:8] = addr_i[11:9];
    else        low_o[9:8]  = addr_i[11:10];
  end
endmodule

// File: rtl/nrm_const_div.sv
module nrm_const_div #(
  parameter int unsigned W   = 64,
  parameter int unsigned D_W = 3
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           load_i,
  input  logic [W-1:0]   dividend_i,
  input  logic [D_W-1:0] divisor_i,
  output logic           fin_o,
  output logic [W-1:0]   quot_o
);
  localparam int unsigned CNT_W = $clog2(W);
  localparam int unsigned REM_W = D_W + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

  logic [W-1:0]     acc_q;
  logic [REM_W-1:0] rem_q;
  logic [D_W-1:0]   dsr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q, fin_q;

  logic [REM_W-1:0] rem_sh, rem_nx;
  logic             ge;

  // restoring step: remainder stays below divisor, so D_W bits plus one shift fit REM_W
  assign rem_sh = {rem_q[REM_W-2:0], acc_q[W-1]};
  assign ge     = rem_sh >= {1'b0, dsr_q};
  assign rem_nx = ge ? rem_sh - {1'b0, dsr_q} : rem_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      rem_q <= '0;
      dsr_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      fin_q <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (load_i) begin
        acc_q <= dividend_i;
        rem_q <= '0;
        dsr_q <= divisor_i;
        cnt_q <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        acc_q <= {acc_q[W-2:0], ge};
        rem_q <= rem_nx;
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          run_q <= 1'b0;
          fin_q <= 1'b1;
        end
      end
    end
  end

  assign fin_o  = fin_q;
  assign quot_o = acc_q;
endmodule

// File: rtl/np2_addr_normalizer.sv
module np2_addr_normalizer
  import np2n_pkg::*;
#(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned MODE_W = 4,
  parameter int unsigned CHAN_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [CHAN_W-1:0] chan_cnt_i,
  output logic [ADDR_W-1:0] norm_o,
  output logic              done_o,
  output logic              err_o
);
  logic [ADDR_W-1:0]  dividend, low, quot, placed;
  logic               wide, valid, div_fin;
  logic [DIVSR_W-1:0] divisor;
  logic               accept;

  logic               busy_q, done_q, err_q, wide_q;
  logic [ADDR_W-1:0]  low_q, norm_q;

  nrm_field_map #(.ADDR_W(ADDR_W), .MODE_W(MODE_W)) u_map (
    .addr_i     (addr_i),
    .mode_i     (mode_i),
    .dividend_o (dividend),
    .low_o      (low),
    .wide_o     (wide),
    .valid_o    (valid)
  );

  assign divisor = (chan_cnt_i % CHAN_W'(3) == '0) ? DIVSR_THREE : DIVSR_FIVE;
  assign accept  = start_i && !busy_q;

  nrm_const_div #(.W(ADDR_W), .D_W(DIVSR_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (accept && valid),
    .dividend_i (dividend),
    .divisor_i  (divisor),
    .fin_o      (div_fin),
    .quot_o     (quot)
  );

  assign placed = low_q | (wide_q ? (quot << Q_POS_2K) : (quot << Q_POS_1K));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      wide_q <= 1'b0;
      low_q  <= '0;
      norm_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept && !valid) begin
        done_q <= 1'b1;
        err_q  <= 1'b1;
        norm_q <= '0;
      end else if (accept) begin
        busy_q <= 1'b1;
        low_q  <= low;
        wide_q <= wide;
      end
      if (div_fin) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        err_q  <= 1'b0;
        norm_q <= placed;
      end
    end
  end

  assign norm_o = norm_q;
  assign done_o = done_q;
  assign err_o  = err_q;
endmodule

// File: rtl/np2_addr_normalizer_chk.sv
module np2_addr_normalizer_chk #(
  parameter int unsigned ADDR_W = 64,
  parameter int unsigned MODE_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [MODE_W-1:0] mode_i,
  input logic              busy_i,
  input logic [ADDR_W-1:0] norm_o,
  input logic              done_o,
  input logic              err_o
);
  localparam int unsigned LAT = ADDR_W + 1;

  logic [ADDR_W-1:0] cap_addr;
  logic [MODE_W-1:0] cap_mode;
  logic [7:0]        lat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_addr <= '0;
      cap_mode <= '0;
      lat_q    <= 8'hff;
    end else if (start_i && !busy_i) begin
      cap_addr <= addr_i;
      cap_mode <= mode_i;
      lat_q    <= '0;
    end else if (lat_q != 8'hff) begin
      lat_q <= lat_q + 1'b1;
    end
  end

  AST_ERR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> norm_o == '0);  // R8

  AST_HOLD_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(norm_o) && $stable(err_o));  // R9

  AST_LOW_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !err_o |-> norm_o[7:0] == cap_addr[7:0]);  // R1

  AST_STRIPE_1K: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !err_o && !cap_mode[0] |-> norm_o[9:8] == cap_addr[11:10]);  // R2

  AST_STRIPE_2K: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !err_o && cap_mode[0] |-> norm_o[10:8] == cap_addr[11:9]);  // R2

  AST_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !err_o |-> lat_q == 8'(LAT));  // R10
endmodule

bind np2_addr_normalizer np2_addr_normalizer_chk #(.ADDR_W(ADDR_W), .MODE_W(MODE_W)) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .addr_i  (addr_i),
  .mode_i  (mode_i),
  .busy_i  (busy_q),
  .norm_o  (norm_o),
  .done_o  (done_o),
  .err_o   (err_o)
);

// File: tb/np2_addr_normalizer_tb_top.sv
`timescale 1ns/1ps
module np2_addr_normalizer_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [63:0] addr_i = '0;
  logic [3:0]  mode_i = '0;
  logic [4:0]  chan_cnt_i = 5'd3;
  logic [63:0] norm_o;
  logic        done_o, err_o;

  int checks = 0;
  int errors = 0;

  always #2 clk_i = ~clk_i;

  np2_addr_normalizer dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .addr_i(addr_i),
    .mode_i(mode_i), .chan_cnt_i(chan_cnt_i), .norm_o(norm_o),
    .done_o(done_o), .err_o(err_o)
  );

  function automatic logic [64:0] model(input logic [63:0] a, input logic [3:0] m,
                                        input logic [4:0] ch);
    logic [63:0] d, dv, q, res;
    logic        k2;
    d  = (ch % 3 == 0) ? 64'd3 : 64'd5;
    k2 = m[0];
    case (m[3:1])
      3'd0: dv = k2 ? a / 64'd16384 : a / 64'd8192;
      3'd1: dv = k2 ? a / 64'd8192 : a / 64'd4096;
      3'd2: dv = k2 ? a / 64'd4096 : (a / 64'd4096) * 2 + {63'd0, a[9]};
      3'd3: dv = k2 ? (a / 64'd4096) * 2 + {63'd0, a[8]}
                    : (a / 64'd4096) * 4 + {62'd0, a[9:8]};
      default: return {1'b1, 64'd0};
    endcase
    q   = dv / d;
    res = {56'd0, a[7:0]};
    res = res + (k2 ? {53'd0, a[11:9], 8'd0} : {54'd0, a[11:10], 8'd0});
    res = res | (k2 ? q * 64'd2048 : q * 64'd1024);
    return {1'b0, res};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [63:0] a, input logic [3:0] m, input logic [4:0] ch,
                        output logic [63:0] r, output logic e, output int lat);
    addr_i = a; mode_i = m; chan_cnt_i = ch; start_i = 1'b1;
    @(posedge clk_i); #1;
    start_i = 1'b0;
    lat = 0;
    while (!done_o) begin
      @(posedge clk_i); #1;
      lat++;
    end
    r = norm_o;
    e = err_o;
  endtask

  function automatic string layout_tag(input logic [2:0] l);
    case (l)
      3'd0: return "R4";
      3'd1: return "R5";
      3'd2: return "R6";
      default: return "R7";
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [63:0] r, r2, ea;
    logic        e;
    int          lat;
    logic [64:0] x;
    logic [63:0] pats [4];
    logic [4:0]  chans [6];
    pats[0] = 64'h0; pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
    pats[2] = 64'h0123_4567_89AB_CDEF; pats[3] = 64'hFEDC_BA98_7654_3A10;
    chans[0] = 5'd3; chans[1] = 5'd5; chans[2] = 5'd6;
    chans[3] = 5'd10; chans[4] = 5'd12; chans[5] = 5'd24;

    repeat (3) @(posedge clk_i);
    #1;
    chk("reset norm", norm_o, 64'd0);
    chk("reset done", {63'd0, done_o}, 64'd0);
    chk("reset err", {63'd0, err_o}, 64'd0);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;

    // sweep layouts, stripes, channel counts and address patterns
    for (int l = 0; l < 4; l++)
      for (int s = 0; s < 2; s++)
        for (int c = 0; c < 6; c++)
          for (int p = 0; p < 4; p++) begin
            logic [3:0] m;
            m = {3'(l), 1'(s)};
            x = model(pats[p], m, chans[c]);
            run_op(pats[p], m, chans[c], r, e, lat);
            chk(layout_tag(3'(l)), r, x[63:0]);
            chk("R8 err clear", {63'd0, e}, 64'd0);
            chk("R10 latency", 64'(lat), 64'd65);
          end

    // R1 and R2 stand-alone field checks
    run_op(64'h0000_0000_0000_0DA5, 4'b0110, 5'd3, r, e, lat);
    chk("R1 low byte", {56'd0, r[7:0]}, 64'hA5);
    chk("R2 1K stripe bits", {62'd0, r[9:8]}, 64'd3);
    run_op(64'h0000_0000_0000_0A5A, 4'b0111, 5'd3, r, e, lat);
    chk("R2 2K stripe bits", {61'd0, r[10:8]}, 64'd5);

    // R3 divisor choice: 6 vs 10 channels give different quotients
    ea = 64'h0000_0000_00F0_0000;
    run_op(ea, 4'b0101, 5'd6, r, e, lat);
    chk("R3 div3", r, (ea / 4096 / 3) * 2048);
    run_op(ea, 4'b0101, 5'd10, r, e, lat);
    chk("R3 div5", r, (ea / 4096 / 5) * 2048);

    // unsupported layouts
    for (int l = 4; l < 8; l++) begin
      run_op(64'hFFFF_0000_FFFF_0000, {3'(l), 1'b0}, 5'd12, r, e, lat);
      chk("R8 zero", r, 64'd0);
      chk("R8 err", {63'd0, e}, 64'd1);
      chk("R8 latency", 64'(lat), 64'd0);
    end

    // start during busy is ignored
    x = model(pats[2], 4'b0010, 5'd12);
    addr_i = pats[2]; mode_i = 4'b0010; chan_cnt_i = 5'd12; start_i = 1'b1;
    @(posedge clk_i); #1;
    start_i = 1'b0;
    repeat (10) @(posedge clk_i);
    #1;
    addr_i = pats[3]; mode_i = 4'b0111; start_i = 1'b1;
    @(posedge clk_i); #1;
    start_i = 1'b0;
    lat = 11;
    while (!done_o) begin @(posedge clk_i); #1; lat++; end
    chk("R9 busy start ignored", norm_o, x[63:0]);
    chk("R10 latency busy", 64'(lat), 64'd65);

    // start in the done cycle is accepted; output held meanwhile
    r2 = norm_o;
    x = model(pats[3], 4'b0001, 5'd24);
    addr_i = pats[3]; mode_i = 4'b0001; chan_cnt_i = 5'd24; start_i = 1'b1;
    @(posedge clk_i); #1;
    start_i = 1'b0;
    chk("R9 held after restart", norm_o, r2);
    chk("R10 pulse one cycle", {63'd0, done_o}, 64'd0);
    addr_i = 64'h5555_5555_5555_5555; mode_i = 4'b1110;
    lat = 0;
    while (!done_o) begin @(posedge clk_i); #1; lat++; end
    chk("R9 done-cycle start accepted", norm_o, x[63:0]);
    chk("R10 latency restart", 64'(lat), 64'd65);

    // output stable with idle inputs changing
    r2 = norm_o;
    repeat (5) begin
      @(posedge clk_i); #1;
      addr_i = addr_i + 64'h1234_5678;
    end
    chk("R9 idle hold", norm_o, r2);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule